// File: doc/BRIEF.md
# Narrow-Access Register Bridge with Write Pacing

This block connects a host that issues 8-, 16- and 32-bit register accesses to a peripheral register file that only accepts aligned 32-bit reads and writes. A narrow write becomes a locked read-modify-write on the 32-bit side. A narrow read becomes an aligned word read, and the bridge returns the selected lane shifted down to bit 0. A full-word write passes straight through.

Two behaviours handle quirks of the peripheral. First, one 16-bit register (the transfer-mode halfword at `MODE_OFF`) is never written downstream on its own. A write to it reads the containing word, merges the new halfword, and keeps the result in an internal 32-bit shadow. A later 16-bit write to its partner halfword (`CMD_OFF`, in the same aligned word) takes its old value from that shadow and sends both halves in one 32-bit write. Second, the peripheral can lose writes that arrive too close together, so downstream writes are spaced by a pacing interval. That interval is two periods of the slowest card clock plus one microsecond, converted to system clock cycles. Reads are never delayed by this interval.

The bridge handles one host request at a time. The host sees `up_ready` low from the cycle a request is accepted until its downstream work is finished.

Top module: `subword_wr_adapter`

## Requirements
- R1: A byte write (`up_size`=2'b00, data in `up_wdata[7:0]`) reads the aligned word at `up_addr` with bits [1:0] cleared, replaces byte lane `up_addr[1:0]` (bits 8*lane+7 down to 8*lane), and writes the word back in one downstream write.
- R2: A halfword write (`up_size`=2'b01, data in `up_wdata[15:0]`) to any address other than `MODE_OFF` and `CMD_OFF` reads the aligned word and replaces bits [15:0] when `up_addr[1]`=0, or bits [31:16] when `up_addr[1]`=1. It then writes the word back.
- R3: A word write (`up_size`=2'b10) makes exactly one downstream write of `up_wdata` and no downstream read.
- R4: A read makes one aligned downstream read and no write. `up_rdata` returns the addressed byte or halfword in its low bits with the upper bits zero, or the full word for size 2'b10, while `up_rvalid` is high for one cycle.
- R5: A halfword write to `MODE_OFF` (default 0x0C) makes one downstream read and no downstream write. The downstream word is left unchanged, and the merged word is kept in the shadow.
- R6: A halfword write to `CMD_OFF` (default 0x0E) makes no downstream read. It merges into the shadow word (zero after reset) and makes one downstream write of the result.
- R7: Two downstream write handshakes are at least `GAP_CYCLES` clock cycles apart. When a write is waiting and `dn_ready` is high, it is issued exactly `GAP_CYCLES`+1 cycles after the previous write.
- R8: Downstream reads are issued without waiting for the pacing interval.
- R9: Every downstream address has bits [1:0] zero. While `dn_ready` is low, `dn_valid`, `dn_addr`, `dn_write` and `dn_wdata` hold their values.
- R10: `up_ready` is low from acceptance until the request finishes, and no downstream access is made while `up_ready` is high. The read and write of one read-modify-write are therefore adjacent downstream accesses.
- R11: After reset `up_ready` is high, and `dn_valid` and `up_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Host request valid |
| up_ready | output | 1 | Host request accepted when high with valid |
| up_addr | input | ADDR_W | Host byte address |
| up_size | input | 2 | 00 byte, 01 halfword, 10 word |
| up_write | input | 1 | 1 for write, 0 for read |
| up_wdata | input | 32 | Host write data, low-aligned for narrow sizes |
| up_rvalid | output | 1 | One-cycle read response strobe |
| up_rdata | output | 32 | Read data, lane shifted to bit 0 |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_addr | output | ADDR_W | Word-aligned downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write word |
| dn_rvalid | input | 1 | Read response, one cycle after a read handshake |
| dn_rdata | input | 32 | Downstream read word |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that downstream addresses are aligned, that a stalled request stays stable, and that no downstream traffic occurs while the host side is idle. It also checks that a read response always follows a downstream response, and it uses its own cycle counter to check that write handshakes are never closer than the pacing interval. The data-path behaviours need the bench's scenarios: byte and halfword lane merging, lane extraction on reads, the shadow absorbing a mode write, the command write merging the shadow (including the zero value after reset), exact write spacing, and reads slipping past a pending pacing window.

// File: rtl/sbw_pkg.sv
package sbw_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10
   } size_e;

   typedef enum logic [2:0] {
      K_READ,
      K_RMW,
      K_WORD,
      K_SHADOW,
      K_CMD
   } kind_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_REQ,
      ST_RD_WAIT,
      ST_MERGE,
      ST_WR_REQ
   } state_e;

endpackage

// File: rtl/sbw_lane_unit.sv
module sbw_lane_unit
   import sbw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [1:0]        lane,
   input  size_e             size,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] merged,
   output logic [DATA_W-1:0] extracted
);
   localparam int LANES = DATA_W / 8;

   if (LANES != 4) begin : g_bad_width
      $error("sbw_lane_unit needs four byte lanes");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] IDX = 2'(i);
      logic       en;
      logic [7:0] src;
      always_comb begin
         case (size)
            SZ_BYTE: begin
               en  = (lane == IDX);
               src = wdata[7:0];
            end
            SZ_HALF: begin
               en  = (lane[1] == IDX[1]);
               src = wdata[8*(i%2) +: 8];
            end
            default: begin
               en  = 1'b1;
               src = wdata[8*i +: 8];
            end
         endcase
      end
      assign merged[8*i +: 8] = en ? src : old_word[8*i +: 8];
   end

   logic [DATA_W-1:0] byte_shift;
   logic [DATA_W-1:0] half_shift;

   always_comb begin
      byte_shift = old_word >> (8 * lane);
      half_shift = lane[1] ? (old_word >> 16) : old_word;
      case (size)
         SZ_BYTE: extracted = {{(DATA_W-8){1'b0}}, byte_shift[7:0]};
         SZ_HALF: extracted = {{(DATA_W-16){1'b0}}, half_shift[15:0]};
         default: extracted = old_word;
      endcase
   end
endmodule

// File: rtl/sbw_gap_timer.sv
module sbw_gap_timer #(
   parameter int GAP_CYCLES = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic idle
);
   localparam int CNT_W = $clog2(GAP_CYCLES + 1);

   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("sbw_gap_timer needs GAP_CYCLES of at least one");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (fire) begin
         cnt_q <= CNT_W'(GAP_CYCLES);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign idle = (cnt_q == '0);
endmodule

// File: rtl/subword_wr_adapter.sv
module subword_wr_adapter
   import sbw_pkg::*;
#(
   parameter int              ADDR_W      = 8,
   parameter int              DATA_W      = 32,
   parameter int              CLK_HZ      = 100_000_000,
   parameter int              MIN_CARD_HZ = 400_000,
   parameter logic [ADDR_W-1:0] MODE_OFF  = 'h0C,
   parameter logic [ADDR_W-1:0] CMD_OFF   = 'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   output logic              up_ready,
   input  logic [ADDR_W-1:0] up_addr,
   input  logic [1:0]        up_size,
   input  logic              up_write,
   input  logic [DATA_W-1:0] up_wdata,
   output logic              up_rvalid,
   output logic [DATA_W-1:0] up_rdata,
   output logic              dn_valid,
   input  logic              dn_ready,
   output logic [ADDR_W-1:0] dn_addr,
   output logic              dn_write,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic              dn_rvalid,
   input  logic [DATA_W-1:0] dn_rdata
);
   localparam int GAP_US     = (2 * 1_000_000) / MIN_CARD_HZ + 1;
   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int GAP_CYCLES = GAP_US * CYC_PER_US;

   if (DATA_W != 32) begin : g_bad_data
      $error("subword_wr_adapter supports a 32-bit data path only");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("subword_wr_adapter needs at least three address bits");
   end
   if (CYC_PER_US < 1) begin : g_bad_clk
      $error("subword_wr_adapter needs a clock of at least 1 MHz");
   end
   if ((MODE_OFF[ADDR_W-1:2] != CMD_OFF[ADDR_W-1:2]) || MODE_OFF[0] || CMD_OFF[0]
       || (MODE_OFF[1] == CMD_OFF[1])) begin : g_bad_pair
      $error("mode and command halfwords must share one aligned word");
   end

   state_e            st_q;
   kind_e             kind_q;
   kind_e             kind_in;
   size_e             size_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] wr_word_q;
   logic [DATA_W-1:0] shadow_q;
   logic [DATA_W-1:0] old_word;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] extracted;
   logic              gap_idle;
   logic              wr_fire;

   // request classification at the host edge
   always_comb begin
      if (!up_write) begin
         kind_in = K_READ;
      end else if (size_e'(up_size) == SZ_BYTE) begin
         kind_in = K_RMW;
      end else if (size_e'(up_size) == SZ_HALF) begin
         if (up_addr == MODE_OFF)     kind_in = K_SHADOW;
         else if (up_addr == CMD_OFF) kind_in = K_CMD;
         else                         kind_in = K_RMW;
      end else begin
         kind_in = K_WORD;
      end
   end

   assign old_word = (kind_q == K_CMD) ? shadow_q : dn_rdata;

   sbw_lane_unit #(
      .DATA_W (DATA_W)
   ) lane_i (
      .old_word  (old_word),
      .lane      (addr_q[1:0]),
      .size      (size_q),
      .wdata     (wdata_q),
      .merged    (merged),
      .extracted (extracted)
   );

   assign wr_fire = dn_valid && dn_ready && dn_write;

   sbw_gap_timer #(
      .GAP_CYCLES (GAP_CYCLES)
   ) gap_i (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (wr_fire),
      .idle  (gap_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         kind_q    <= K_READ;
         size_q    <= SZ_BYTE;
         addr_q    <= '0;
         wdata_q   <= '0;
         wr_word_q <= '0;
         shadow_q  <= '0;
         up_rvalid <= 1'b0;
         up_rdata  <= '0;
      end else begin
         up_rvalid <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (up_valid) begin
                  kind_q  <= kind_in;
                  size_q  <= size_e'(up_size);
                  addr_q  <= up_addr;
                  wdata_q <= up_wdata;
                  case (kind_in)
                     K_WORD: begin
                        wr_word_q <= up_wdata;
                        st_q      <= ST_WR_REQ;
                     end
                     K_CMD:   st_q <= ST_MERGE;
                     default: st_q <= ST_RD_REQ;
                  endcase
               end
            end
            ST_RD_REQ: begin
               if (dn_ready) st_q <= ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
               if (dn_rvalid) begin
                  case (kind_q)
                     K_READ: begin
                        up_rdata  <= extracted;
                        up_rvalid <= 1'b1;
                        st_q      <= ST_IDLE;
                     end
                     K_SHADOW: begin
                        shadow_q <= merged;
                        st_q     <= ST_IDLE;
                     end
                     default: begin
                        wr_word_q <= merged;
                        st_q      <= ST_WR_REQ;
                     end
                  endcase
               end
            end
            ST_MERGE: begin
               wr_word_q <= merged;
               st_q      <= ST_WR_REQ;
            end
            ST_WR_REQ: begin
               if (gap_idle && dn_ready) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign up_ready = (st_q == ST_IDLE);
   assign dn_valid = (st_q == ST_RD_REQ) || ((st_q == ST_WR_REQ) && gap_idle);
   assign dn_write = (st_q == ST_WR_REQ);
   assign dn_addr  = {addr_q[ADDR_W-1:2], 2'b00};
   assign dn_wdata = wr_word_q;
endmodule

// File: rtl/sbw_checker.sv
module sbw_checker #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int GAP_CYCLES = 600
) (
   input logic              clk,
   input logic              rst_n,
   input logic              up_ready,
   input logic              up_rvalid,
   input logic              dn_valid,
   input logic              dn_ready,
   input logic [ADDR_W-1:0] dn_addr,
   input logic              dn_write,
   input logic [DATA_W-1:0] dn_wdata,
   input logic              dn_rvalid
);
   // cycles since the last write handshake, saturating at the interval
   int unsigned since_wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_wr_q <= GAP_CYCLES;
      end else if (dn_valid && dn_ready && dn_write) begin
         since_wr_q <= 1;
      end else if (since_wr_q < GAP_CYCLES) begin
         since_wr_q <= since_wr_q + 1;
      end
   end

   AST_WR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_ready && dn_write) |-> (since_wr_q >= GAP_CYCLES)); // R7

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      dn_valid |-> (dn_addr[1:0] == 2'b00)); // R9

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write)
                                   && $stable(dn_wdata))); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      up_ready |-> !dn_valid); // R10

   AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      up_rvalid |-> $past(dn_rvalid)); // R4
endmodule

bind subword_wr_adapter sbw_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .GAP_CYCLES (GAP_CYCLES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .up_ready  (up_ready),
   .up_rvalid (up_rvalid),
   .dn_valid  (dn_valid),
   .dn_ready  (dn_ready),
   .dn_addr   (dn_addr),
   .dn_write  (dn_write),
   .dn_wdata  (dn_wdata),
   .dn_rvalid (dn_rvalid)
);

// File: tb/subword_wr_adapter_tb_top.sv
module subword_wr_adapter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TB_CLK_HZ  = 10_000_000;
   localparam int TB_GAP     = ((2 * 1_000_000) / 400_000 + 1) * (TB_CLK_HZ / 1_000_000);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        up_valid = 1'b0;
   logic        up_ready;
   logic [7:0]  up_addr = '0;
   logic [1:0]  up_size = '0;
   logic        up_write = 1'b0;
   logic [31:0] up_wdata = '0;
   logic        up_rvalid;
   logic [31:0] up_rdata;
   logic        dn_valid;
   logic        dn_ready;
   logic [7:0]  dn_addr;
   logic        dn_write;
   logic [31:0] dn_wdata;
   logic        dn_rvalid;
   logic [31:0] dn_rdata;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   subword_wr_adapter #(
      .ADDR_W (8),
      .DATA_W (32),
      .CLK_HZ (TB_CLK_HZ)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_size(up_size),
      .up_write(up_write), .up_wdata(up_wdata), .up_rvalid(up_rvalid), .up_rdata(up_rdata),
      .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_write(dn_write),
      .dn_wdata(dn_wdata), .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
   );

   // downstream register file model
   logic [31:0] mem [16];
   int          cyc = 0;
   int          wr_cnt = 0;
   int          rd_cnt = 0;
   int          last_wr = 0;
   int          prev_wr = 0;
   int          last_rd = 0;
   logic        stall_mode = 1'b0;
   logic        pl_en = 1'b0;
   logic [3:0]  pl_idx = '0;
   logic [31:0] pl_val = '0;

   assign dn_ready = stall_mode ? cyc[0] : 1'b1;

   always @(posedge clk) begin
      cyc       <= cyc + 1;
      dn_rvalid <= 1'b0;
      if (pl_en) mem[pl_idx] <= pl_val;
      if (dn_valid && dn_ready) begin
         if (dn_write) begin
            mem[dn_addr[5:2]] <= dn_wdata;
            wr_cnt  <= wr_cnt + 1;
            prev_wr <= last_wr;
            last_wr <= cyc;
         end else begin
            dn_rvalid <= 1'b1;
            dn_rdata  <= mem[dn_addr[5:2]];
            rd_cnt    <= rd_cnt + 1;
            last_rd   <= cyc;
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic preload(input logic [3:0] idx, input logic [31:0] val);
      @(negedge clk);
      pl_en = 1'b1; pl_idx = idx; pl_val = val;
      @(negedge clk);
      pl_en = 1'b0;
   endtask

   task automatic host_op(input logic [7:0] a, input logic [1:0] sz, input logic wr,
                          input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      up_valid = 1'b1; up_addr = a; up_size = sz; up_write = wr; up_wdata = wd;
      while (!up_ready) @(negedge clk);
      @(negedge clk);
      up_valid = 1'b0;
      rd = '0;
      if (!wr) begin
         while (!up_rvalid) @(negedge clk);
         rd = up_rdata;
      end else begin
         while (!up_ready) @(negedge clk);
      end
   endtask

   task automatic t_reset();
      check("R11 up_ready", 32'(up_ready), 32'd1);
      check("R11 dn_valid", 32'(dn_valid), 32'd0);
      check("R11 up_rvalid", 32'(up_rvalid), 32'd0);
   endtask

   task automatic t_cmd_from_reset_shadow();
      logic [31:0] d;
      int r0;
      preload(4'd3, 32'hFFFF_FFFF);
      r0 = rd_cnt;
      host_op(8'h0E, 2'b01, 1'b1, 32'h0000_5555, d);
      check("R6 cmd merges zero shadow", mem[3], 32'h5555_0000);
      check("R6 cmd makes no read", 32'(rd_cnt - r0), 32'd0);
   endtask

   task automatic t_word_write();
      logic [31:0] d;
      int r0, w0;
      r0 = rd_cnt; w0 = wr_cnt;
      host_op(8'h10, 2'b10, 1'b1, 32'hDEAD_BEEF, d);
      check("R3 word data", mem[4], 32'hDEAD_BEEF);
      check("R3 one write", 32'(wr_cnt - w0), 32'd1);
      check("R3 no read", 32'(rd_cnt - r0), 32'd0);
   endtask

   task automatic t_byte_write();
      logic [31:0] d;
      logic [31:0] exp;
      int r0, w0;
      exp = 32'hDEAD_BEEF;
      for (int l = 0; l < 4; l++) begin
         r0 = rd_cnt; w0 = wr_cnt;
         host_op(8'h10 + 8'(l), 2'b00, 1'b1, 32'hFFFF_FF00 | 32'(8'h11 * (l + 1)), d);
         exp[8*l +: 8] = 8'(8'h11 * (l + 1));
         check("R1 byte lane merge", mem[4], exp);
         check("R1 one read", 32'(rd_cnt - r0), 32'd1);
         check("R1 one write", 32'(wr_cnt - w0), 32'd1);
         check("R10 read before write", 32'(last_rd < last_wr), 32'd1);
      end
   endtask

   task automatic t_half_write();
      logic [31:0] d;
      preload(4'd5, 32'h0123_4567);
      host_op(8'h16, 2'b01, 1'b1, 32'hFFFF_CAFE, d);
      check("R2 upper half", mem[5], 32'hCAFE_4567);
      host_op(8'h14, 2'b01, 1'b1, 32'h0000_F00D, d);
      check("R2 lower half", mem[5], 32'hCAFE_F00D);
   endtask

   task automatic t_reads();
      logic [31:0] d;
      int w0, r0;
      preload(4'd8, 32'h8765_4321);
      w0 = wr_cnt;
      for (int l = 0; l < 4; l++) begin
         r0 = rd_cnt;
         host_op(8'h20 + 8'(l), 2'b00, 1'b0, 32'h0, d);
         check("R4 byte read", d, 32'((32'h8765_4321 >> (8 * l)) & 32'hFF));
         check("R4 one read", 32'(rd_cnt - r0), 32'd1);
      end
      host_op(8'h22, 2'b01, 1'b0, 32'h0, d);
      check("R4 upper half read", d, 32'h0000_8765);
      host_op(8'h20, 2'b01, 1'b0, 32'h0, d);
      check("R4 lower half read", d, 32'h0000_4321);
      host_op(8'h20, 2'b10, 1'b0, 32'h0, d);
      check("R4 word read", d, 32'h8765_4321);
      check("R4 reads make no write", 32'(wr_cnt - w0), 32'd0);
   endtask

   task automatic t_shadow_pair();
      logic [31:0] d;
      int r0, w0;
      preload(4'd3, 32'h7777_8888);
      r0 = rd_cnt; w0 = wr_cnt;
      host_op(8'h0C, 2'b01, 1'b1, 32'h0000_1234, d);
      check("R5 mode write reads once", 32'(rd_cnt - r0), 32'd1);
      check("R5 mode write sends nothing", 32'(wr_cnt - w0), 32'd0);
      host_op(8'h0C, 2'b10, 1'b0, 32'h0, d);
      check("R5 downstream word untouched", d, 32'h7777_8888);
      r0 = rd_cnt; w0 = wr_cnt;
      host_op(8'h0E, 2'b01, 1'b1, 32'h0000_ABCD, d);
      check("R6 pair merged", mem[3], 32'hABCD_1234);
      check("R6 no read", 32'(rd_cnt - r0), 32'd0);
      check("R6 one write", 32'(wr_cnt - w0), 32'd1);
   endtask

   task automatic t_spacing();
      logic [31:0] d;
      host_op(8'h28, 2'b10, 1'b1, 32'h1111_1111, d);
      host_op(8'h2C, 2'b10, 1'b1, 32'h2222_2222, d);
      check("R7 write spacing", 32'(last_wr - prev_wr), 32'(TB_GAP + 1));
      check("R7 second word", mem[11], 32'h2222_2222);
   endtask

   task automatic t_read_unpaced();
      logic [31:0] d;
      host_op(8'h24, 2'b10, 1'b1, 32'h5A5A_A5A5, d);
      host_op(8'h24, 2'b10, 1'b0, 32'h0, d);
      check("R8 read data", d, 32'h5A5A_A5A5);
      check("R8 read inside pacing window", 32'((last_rd - last_wr) < TB_GAP), 32'd1);
   endtask

   task automatic t_stall();
      logic [31:0] d;
      stall_mode = 1'b1;
      host_op(8'h30, 2'b10, 1'b1, 32'hAABB_CCDD, d);
      host_op(8'h32, 2'b00, 1'b1, 32'h0000_0099, d);
      check("R9 stalled byte write", mem[12], 32'hAA99_CCDD);
      host_op(8'h33, 2'b00, 1'b0, 32'h0, d);
      check("R9 stalled byte read", d, 32'h0000_00AA);
      stall_mode = 1'b0;
   endtask

   initial begin
      repeat (200_000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmd_from_reset_shadow();
      t_word_write();
      t_byte_write();
      t_half_write();
      t_reads();
      t_shadow_pair();
      t_spacing();
      t_read_unpaced();
      t_stall();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule